// File: doc/BRIEF.md
# Envelope Interrupt Flag Register

This block keeps one interrupt flag for each voice channel of an envelope engine. A flag can be set by either of two events on its channel. The first is a toggle of that channel's envelope buffer, which counts only while the global toggle enable is high. The second is the channel's current envelope level being at or below a fixed threshold, which counts only while the global drop enable is high. Software reads all flags in one word. It clears chosen flags by writing ones to their bit positions.

A single interrupt request line pulses for one cycle whenever at least one flag goes from clear to set. When a set event and a software clear hit the same bit in the same cycle, the set event wins, so no event is lost. The drop condition is a level, not an edge. While a channel stays at or below the threshold and the drop enable is high, the channel's flag is set again on every cycle.

Top module: `env_irq_flags`

## Requirements
- R1: While `rst_n` is low, `flags` and `irq` are all zero.
- R2: A 1 on `env_toggle[n]` while `tog_ie` is 1 sets bit n of `flags` one clock later. While `tog_ie` is 0, toggles have no effect on `flags` or `irq`.
- R3: While `drop_ie` is 1, channel n's level field `env_level[n*16 +: 16]` sets bit n of `flags` one clock later if the field is unsigned less than or equal to 16'h0FFF. A value of 16'h1000 or above sets nothing. While `drop_ie` is 0, the level has no effect.
- R4: A clock with `wr_en` high clears every flag whose bit in `wr_data` is 1, unless a set event hits that bit. Bits written with 0 are unchanged. While `wr_en` is low, `wr_data` has no effect.
- R5: When a set event and a write-1 clear target the same bit in the same cycle, the bit is 1 after that clock.
- R6: `irq` is high for exactly the one cycle after a clock in which at least one flag went from 0 to 1. It stays low when set events only hit flags that are already 1. Many simultaneous rises give one single-cycle pulse.
- R7: `flags` always shows the current value of all flag bits, with bit n for channel n.
- R8: The drop set is level-qualified. While a channel's level stays at or below the threshold and `drop_ie` is 1, a write-1 clear of that bit does not take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tog_ie | input | 1 | Global enable for buffer-toggle set events |
| drop_ie | input | 1 | Global enable for envelope-drop set events |
| env_toggle | input | 32 | Per-channel envelope buffer toggle strobes |
| env_level | input | 512 | Per-channel current envelope level, 16 bits each, channel n at bits n*16+15..n*16 |
| wr_en | input | 1 | Write strobe for the clear operation |
| wr_data | input | 32 | Write-one-to-clear mask |
| flags | output | 32 | Current flag values, bit n for channel n |
| irq | output | 1 | One-cycle interrupt pulse on any flag rising |

## Verification
Both `flags` and `irq` come from registers, so each result is due exactly one clock after the cycle in which its stimulus is presented. The bench changes inputs on the falling edge. It lets one rising edge pass and samples both outputs on the next falling edge, which is the only window in which an `irq` pulse is visible. For the pulse-width check the bench holds quiet inputs for one more clock and confirms that `irq` has dropped. For the level-qualified drop check it samples again after a second clock with the same inputs.

// File: rtl/env_irq_flags.sv
module env_irq_flags #(
  parameter int CHANNELS = 32,
  parameter int ENV_W = 16,
  parameter logic [ENV_W-1:0] DROP_LIMIT = 16'h0FFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tog_ie,
  input  logic                      drop_ie,
  input  logic [CHANNELS-1:0]       env_toggle,
  input  logic [CHANNELS*ENV_W-1:0] env_level,
  input  logic                      wr_en,
  input  logic [CHANNELS-1:0]       wr_data,
  output logic [CHANNELS-1:0]       flags,
  output logic                      irq
);

  logic [CHANNELS-1:0] below;
  logic [CHANNELS-1:0] set_vec;
  logic [CHANNELS-1:0] clr_vec;
  logic [CHANNELS-1:0] flags_nx;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_cmp
    assign below[ch] = env_level[ch*ENV_W +: ENV_W] <= DROP_LIMIT;
  end

  assign set_vec  = ({CHANNELS{tog_ie}} & env_toggle) | ({CHANNELS{drop_ie}} & below);
  assign clr_vec  = {CHANNELS{wr_en}} & wr_data;
  assign flags_nx = (flags & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nx;
      irq   <= |(flags_nx & ~flags);
    end
  end

endmodule

// File: rtl/env_irq_flags_chk.sv
module env_irq_flags_chk #(
  parameter int CHANNELS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tog_ie,
  input logic                drop_ie,
  input logic [CHANNELS-1:0] env_toggle,
  input logic                wr_en,
  input logic [CHANNELS-1:0] wr_data,
  input logic [CHANNELS-1:0] flags,
  input logic                irq
);

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (flags == '0 && !irq)); // R1

  AST_TOGGLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tog_ie |=> ((flags & $past(env_toggle)) == $past(env_toggle))); // R2

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tog_ie && !drop_ie) |=> ((flags & $past(wr_data)) == '0)); // R4

  AST_NO_DROP_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags & $past(flags)) == $past(flags))); // R4

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == |(flags & ~$past(flags)))); // R6

endmodule

bind env_irq_flags env_irq_flags_chk #(.CHANNELS(CHANNELS)) i_chk (
  .clk(clk), .rst_n(rst_n), .tog_ie(tog_ie), .drop_ie(drop_ie),
  .env_toggle(env_toggle), .wr_en(wr_en), .wr_data(wr_data),
  .flags(flags), .irq(irq)
);

// File: tb/test_env_irq_flags.sv
module test_env_irq_flags;
  localparam int CH = 32;
  localparam int EW = 16;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tog_ie = 1'b0, drop_ie = 1'b0, wr_en = 1'b0;
  logic [CH-1:0] env_toggle = '0, wr_data = '0, low_mask = '0;
  logic [CH*EW-1:0] env_level;
  logic [EW-1:0] low_val = 16'h0FFF;
  logic [CH-1:0] flags;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < CH; i++)
      env_level[i*EW +: EW] = low_mask[i] ? low_val : 16'h1000;

  env_irq_flags i_env_irq_flags (
    .clk(clk), .rst_n(rst_n), .tog_ie(tog_ie), .drop_ie(drop_ie),
    .env_toggle(env_toggle), .env_level(env_level), .wr_en(wr_en),
    .wr_data(wr_data), .flags(flags), .irq(irq)
  );

  // {tog_ie, drop_ie, toggle, low channels, wr_en, wr_data, exp flags, exp irq}
  localparam logic [131:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h0000_0005, 32'h0, 1'b0, 32'h0,         32'h0000_0005, 1'b1}, // R2
    {1'b0, 1'b0, 32'h0000_00F0, 32'h0, 1'b0, 32'h0,         32'h0000_0005, 1'b0}, // R2 gated
    {1'b0, 1'b1, 32'h0,  32'h0000_0100, 1'b0, 32'h0,         32'h0000_0105, 1'b1}, // R3
    {1'b0, 1'b0, 32'h0,  32'h0000_0100, 1'b1, 32'h0000_0101, 32'h0000_0004, 1'b0}, // R4 R3 gated
    {1'b0, 1'b0, 32'h0,  32'h0, 1'b0, 32'hFFFF_FFFF,         32'h0000_0004, 1'b0}, // R4 no wr_en
    {1'b0, 1'b0, 32'h0,  32'h0, 1'b1, 32'h0,                 32'h0000_0004, 1'b0}, // R4 zeros
    {1'b1, 1'b0, 32'h0000_0004, 32'h0, 1'b1, 32'h0000_0004,  32'h0000_0004, 1'b0}, // R5 R6
    {1'b0, 1'b0, 32'h0,  32'h0, 1'b1, 32'h0000_0004,         32'h0000_0000, 1'b0}, // R4
    {1'b1, 1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0, 32'h0,  32'h8000_0001, 1'b1}, // R2 R3 R7
    {1'b0, 1'b1, 32'h0,  32'h0000_0001, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0}, // R8
    {1'b0, 1'b0, 32'h0,  32'h0000_0001, 1'b1, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R4
    {1'b0, 1'b1, 32'h0,  32'h0000_0001, 1'b0, 32'h0,         32'h0000_0001, 1'b1}  // R3 R6
  };

  task automatic check(input string req, input logic [CH-1:0] ef, input logic ei);
    checks++;
    if (flags !== ef || irq !== ei) begin
      errors++;
      $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b", req, flags, irq, ef, ei);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    tog_ie = 0; drop_ie = 0; env_toggle = '0; low_mask = '0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tog_ie = 1; env_toggle = '1;
    step();
    check("R1 reset", '0, 1'b0);
    quiet();
    rst_n = 1;
    for (int v = 0; v < NV; v++) begin
      {tog_ie, drop_ie, env_toggle, low_mask, wr_en, wr_data} = VEC[v][131:33];
      step();
      check($sformatf("vector %0d (R2-R8 table)", v), VEC[v][32:1], VEC[v][0]);
    end
    // R8: level-qualified re-set overrides repeated clear
    quiet(); drop_ie = 1; low_mask = 32'h1; wr_en = 1; wr_data = 32'h1;
    step();
    check("R8 hold", 32'h1, 1'b0);
    // R3: level zero sets
    quiet(); wr_en = 1; wr_data = '1;
    step();
    low_val = 16'h0000; wr_en = 0; drop_ie = 1; low_mask = 32'h0000_0200;
    step();
    check("R3 zero level", 32'h0000_0200, 1'b1);
    low_val = 16'h0FFF;
    // R6: all bits rising at once give a single one-cycle pulse
    quiet(); wr_en = 1; wr_data = '1;
    step();
    quiet(); tog_ie = 1; env_toggle = '1;
    step();
    check("R6 many rises", '1, 1'b1);
    quiet();
    step();
    check("R6 pulse ends", '1, 1'b0);
    // R1: reset mid-run clears all
    rst_n = 0;
    step();
    check("R1 mid-run reset", '0, 1'b0);
    rst_n = 1;
    step();
    check("R7 idle after reset", '0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule